// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small CPU core. It gathers interrupt request flags from peripheral sources and sorts them into sixteen priority levels, where level 15 is the highest. Every clock it reports whether any request may currently be taken, together with the address of the vector word for the winning level. That address is 0xFFE0 plus twice the level number. When the CPU acknowledges, the block latches the address and holds it for the CPU's vector fetch. It also emits one-cycle clear pulses: one for the flag of a single-source vector, and one for the enable that must drop so the handler is not entered again at once.

There are three classes of request. System reset always uses the top vector word, 0xFFFE. Three non-maskable sources share level 14. Each of them is blocked only by its own enable, and the global enable has no effect on them. All other sources are maskable and need both their own enable and the global enable. Some levels collect several flags: the shared-timer group, port A and port B. Some levels have no source at all.

The block also watches the CPU's instruction-fetch bus. A fetch from the peripheral register window, or from an unpopulated address hole, raises a system reset request. Data accesses to the same addresses raise nothing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `irq_req` is high, `pend_vec` equals 0xFFE0 + 2×L, where L is the highest pending level. Single sources map as follows: `sng_flag` bit 0 to level 12, bit 1 to level 10, bit 2 to level 6, bit 3 to level 3 and bit 4 to level 0. The shared-timer group is level 5, port A is level 4 and port B is level 1.
- R2: A non-maskable source with its own flag and enable set drives `irq_req` high and `pend_vec` to 0xFFFC. This holds whatever the value of `gie`.
- R3: A maskable source is pending only when its flag, its own enable and `gie` are all high. With `gie` low and no enabled non-maskable source, `irq_req` is low.
- R4: Any single flag of a grouped level (shared timer, port A, port B) that is set and enabled raises that level's request.
- R5: Levels 13, 11, 9, 8, 7 and 2 have no source and are never selected.
- R6: In a cycle with `irq_ack` high and `irq_req` high, `vec_addr` takes the value of `pend_vec` at the next clock edge. `vec_addr` then keeps that value until a later accepted acknowledge or a reset request. An acknowledge while `irq_req` is low is ignored.
- R7: One cycle after an accepted acknowledge of a single-source level, the matching bit of `sng_clr` is high for exactly one cycle. Grouped and non-maskable levels produce no `sng_clr` pulse.
- R8: One cycle after an accepted acknowledge, `gie_clr` pulses for one cycle if the level was maskable. If the level was 14, `nmi_en_clr` pulses instead. The two pulses never occur together.
- R9: A fetch (`fetch_valid` high) from 0x0000 to 0x01FF raises `sys_rst_req` one cycle later.
- R10: A fetch from 0x0300 to 0x0BFF, or from 0x1100 to the parameter `FETCH_HI` (default 0x7FFF), also raises `sys_rst_req` one cycle later. No other fetch address does, including 0x0200 to 0x02FF and 0x0C00 to 0x10FF.
- R11: With `fetch_valid` low, no address on `fetch_addr` raises `sys_rst_req`.
- R12: Any bit of `rst_src` (external pin, watchdog, flash key) raises `sys_rst_req` one cycle later. After power-up, and whenever `sys_rst_req` is high, `vec_addr` reads 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gie | input | 1 | Global interrupt enable |
| nmi_flag | input | 3 | Non-maskable flags (pin, oscillator fault, flash access) |
| nmi_en | input | 3 | Individual enables of the non-maskable flags |
| sng_flag | input | 5 | Single-source maskable flags |
| sng_en | input | 5 | Enables of the single-source flags |
| tmr_flag | input | 3 | Shared-timer group flags (level 5) |
| tmr_en | input | 3 | Shared-timer group enables |
| pa_flag | input | 8 | Port A flags (level 4) |
| pa_en | input | 8 | Port A enables |
| pb_flag | input | 8 | Port B flags (level 1) |
| pb_en | input | 8 | Port B enables |
| rst_src | input | 3 | Reset causes: external, watchdog, flash key |
| fetch_valid | input | 1 | Qualifies `fetch_addr` as an instruction fetch |
| fetch_addr | input | 16 | CPU address |
| irq_ack | input | 1 | CPU acknowledges the pending request |
| irq_req | output | 1 | A request may be taken now |
| pend_vec | output | 16 | Vector word address of the current winner |
| vec_addr | output | 16 | Latched vector word address |
| sng_clr | output | 5 | One-cycle clear pulses for single-source flags |
| gie_clr | output | 1 | One-cycle pulse: drop the global enable |
| nmi_en_clr | output | 1 | One-cycle pulse: drop the non-maskable enables |
| sys_rst_req | output | 1 | System reset request |

## Verification
The assertions check, on every cycle, the rules that hold at each instant. A pending vector is always in the vector table and never in an empty slot. An enabled non-maskable source always wins, and nothing is requested with `gie` low unless a non-maskable source is enabled. The latched vector stays still when there is no accepted acknowledge and no reset cause. The clear pulses are one-hot and exclusive, and a reset request always shows the reset vector. Only the bench's scenarios can show the correct priority order across mixed flag patterns, the exact address boundaries of the forbidden fetch ranges, and which clear pulse follows the acknowledge of each kind of level.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int LVL_N    = 16;
  localparam int LVL_W    = $clog2(LVL_N);
  localparam int ADDR_W   = 16;
  localparam logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0;
  localparam logic [ADDR_W-1:0] RST_VEC  = VEC_BASE + ADDR_W'(2 * (LVL_N - 1));
  localparam int NMI_N    = 3;
  localparam int SNG_N    = 5;
  localparam int TMR_N    = 3;
  localparam int PORT_W   = 8;
  localparam int RSRC_N   = 3;
  localparam logic [LVL_W-1:0] NMI_LVL = 4'd14;
  localparam logic [LVL_W-1:0] TMR_LVL = 4'd5;
  localparam logic [LVL_W-1:0] PA_LVL  = 4'd4;
  localparam logic [LVL_W-1:0] PB_LVL  = 4'd1;

  // level served by each single-source maskable flag
  function automatic logic [LVL_W-1:0] sng_level(input int idx);
    case (idx)
      0:       return 4'd12;
      1:       return 4'd10;
      2:       return 4'd6;
      3:       return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] vec_of(input logic [LVL_W-1:0] lvl);
    return VEC_BASE + {{(ADDR_W-LVL_W-1){1'b0}}, lvl, 1'b0};
  endfunction
endpackage

// File: rtl/irq_fetch_guard.sv
module irq_fetch_guard
  import irq_vec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_HI   = 16'h01FF,
  parameter logic [ADDR_W-1:0] HOLE_LO  = 16'h0300,
  parameter logic [ADDR_W-1:0] HOLE_HI  = 16'h0BFF,
  parameter logic [ADDR_W-1:0] UPPER_LO = 16'h1100,
  parameter logic [ADDR_W-1:0] UPPER_HI = 16'h7FFF
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_bad
);
  logic in_reg, in_hole, in_upper;

  always_comb begin
    in_reg   = (fetch_addr <= REG_HI);
    in_hole  = (fetch_addr >= HOLE_LO) && (fetch_addr <= HOLE_HI);
    in_upper = (fetch_addr >= UPPER_LO) && (fetch_addr <= UPPER_HI);
    fetch_bad = fetch_valid && (in_reg || in_hole || in_upper);
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_vec_pkg::*;
(
  input  logic              gie,
  input  logic [NMI_N-1:0]  nmi_flag,
  input  logic [NMI_N-1:0]  nmi_en,
  input  logic [SNG_N-1:0]  sng_flag,
  input  logic [SNG_N-1:0]  sng_en,
  input  logic [TMR_N-1:0]  tmr_flag,
  input  logic [TMR_N-1:0]  tmr_en,
  input  logic [PORT_W-1:0] pa_flag,
  input  logic [PORT_W-1:0] pa_en,
  input  logic [PORT_W-1:0] pb_flag,
  input  logic [PORT_W-1:0] pb_en,
  output logic [LVL_N-1:0]  lvl_pend
);
  logic [SNG_N-1:0] sng_live;

  // one gated request per single-source flag
  genvar gi;
  generate
    for (gi = 0; gi < SNG_N; gi++) begin : g_sng
      assign sng_live[gi] = sng_flag[gi] && sng_en[gi] && gie;
    end
  endgenerate

  always_comb begin
    lvl_pend = '0;
    // non-maskable tier ignores the global enable
    lvl_pend[NMI_LVL] = |(nmi_flag & nmi_en);
    for (int i = 0; i < SNG_N; i++) begin
      if (sng_live[i]) lvl_pend[sng_level(i)] = 1'b1;
    end
    if (gie && |(tmr_flag & tmr_en)) lvl_pend[TMR_LVL] = 1'b1;
    if (gie && |(pa_flag & pa_en))   lvl_pend[PA_LVL]  = 1'b1;
    if (gie && |(pb_flag & pb_en))   lvl_pend[PB_LVL]  = 1'b1;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FETCH_HI = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic [NMI_N-1:0]  nmi_flag,
  input  logic [NMI_N-1:0]  nmi_en,
  input  logic [SNG_N-1:0]  sng_flag,
  input  logic [SNG_N-1:0]  sng_en,
  input  logic [TMR_N-1:0]  tmr_flag,
  input  logic [TMR_N-1:0]  tmr_en,
  input  logic [PORT_W-1:0] pa_flag,
  input  logic [PORT_W-1:0] pa_en,
  input  logic [PORT_W-1:0] pb_flag,
  input  logic [PORT_W-1:0] pb_en,
  input  logic [RSRC_N-1:0] rst_src,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [ADDR_W-1:0] pend_vec,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SNG_N-1:0]  sng_clr,
  output logic              gie_clr,
  output logic              nmi_en_clr,
  output logic              sys_rst_req
);
  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [LVL_N-1:0] lvl_pend;
  logic [LVL_W-1:0] win_lvl;
  logic             any_pend;
  logic             fetch_bad;

  irq_level_map u_map (
    .gie      (gie),
    .nmi_flag (nmi_flag),
    .nmi_en   (nmi_en),
    .sng_flag (sng_flag),
    .sng_en   (sng_en),
    .tmr_flag (tmr_flag),
    .tmr_en   (tmr_en),
    .pa_flag  (pa_flag),
    .pa_en    (pa_en),
    .pb_flag  (pb_flag),
    .pb_en    (pb_en),
    .lvl_pend (lvl_pend)
  );

  irq_prio_enc #(.N(LVL_N)) u_enc (
    .req (lvl_pend),
    .any (any_pend),
    .idx (win_lvl)
  );

  irq_fetch_guard #(.UPPER_HI(FETCH_HI)) u_guard (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_bad   (fetch_bad)
  );

  assign irq_req  = any_pend;
  assign pend_vec = vec_of(win_lvl);

  // next-state logic
  logic              rst_cause, ack_take, vec_en;
  logic [ADDR_W-1:0] vec_d, vec_q;
  logic [SNG_N-1:0]  clr_d, clr_q;
  logic              gclr_d, gclr_q, nclr_d, nclr_q, rreq_d, rreq_q;

  always_comb begin
    rst_cause = (|rst_src) || fetch_bad;
    ack_take  = irq_ack && any_pend && !rst_cause;
    vec_en    = rst_cause || ack_take;
    vec_d     = rst_cause ? RST_VEC : pend_vec;
    for (int i = 0; i < SNG_N; i++) begin
      clr_d[i] = ack_take && (win_lvl == sng_level(i));
    end
    gclr_d = ack_take && (win_lvl != NMI_LVL);
    nclr_d = ack_take && (win_lvl == NMI_LVL);
    rreq_d = rst_cause;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vec_q <= RST_VEC;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      clr_q  <= '0;
      gclr_q <= 1'b0;
      nclr_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      clr_q  <= clr_d;
      gclr_q <= gclr_d;
      nclr_q <= nclr_d;
      rreq_q <= rreq_d;
    end
  end

  assign vec_addr    = vec_q;
  assign sng_clr     = clr_q;
  assign gie_clr     = gclr_q;
  assign nmi_en_clr  = nclr_q;
  assign sys_rst_req = rreq_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic [NMI_N-1:0]  nmi_flag,
  input logic [NMI_N-1:0]  nmi_en,
  input logic [RSRC_N-1:0] rst_src,
  input logic              fetch_valid,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [ADDR_W-1:0] pend_vec,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [SNG_N-1:0]  sng_clr,
  input logic              gie_clr,
  input logic              nmi_en_clr,
  input logic              sys_rst_req
);
  logic nmi_live;
  assign nmi_live = |(nmi_flag & nmi_en);

  // R1
  vec_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_vec[15:5] == 11'h7FF) && (pend_vec[0] == 1'b0));

  // R5
  no_empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !(pend_vec[4:1] inside {4'd13, 4'd11, 4'd9, 4'd8, 4'd7, 4'd2}));

  // R2
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_live |-> irq_req && (pend_vec == 16'hFFFC));

  // R3
  gie_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !nmi_live) |-> !irq_req);

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_ack && irq_req) && (rst_src == '0) && !fetch_valid) |=> $stable(vec_addr));

  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sng_clr));

  // R8
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gie_clr && nmi_en_clr));

  // R11
  data_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && (rst_src == '0)) |=> !sys_rst_req);

  // R12
  rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (vec_addr == 16'hFFFE));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gie         (gie),
  .nmi_flag    (nmi_flag),
  .nmi_en      (nmi_en),
  .rst_src     (rst_src),
  .fetch_valid (fetch_valid),
  .irq_ack     (irq_ack),
  .irq_req     (irq_req),
  .pend_vec    (pend_vec),
  .vec_addr    (vec_addr),
  .sng_clr     (sng_clr),
  .gie_clr     (gie_clr),
  .nmi_en_clr  (nmi_en_clr),
  .sys_rst_req (sys_rst_req)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic [2:0]  nmi_flag = '0, nmi_en = '0;
  logic [4:0]  sng_flag = '0, sng_en = '0;
  logic [2:0]  tmr_flag = '0, tmr_en = '0;
  logic [7:0]  pa_flag = '0, pa_en = '0, pb_flag = '0, pb_en = '0;
  logic [2:0]  rst_src = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [15:0] pend_vec, vec_addr;
  logic [4:0]  sng_clr;
  logic        gie_clr, nmi_en_clr, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .gie(gie),
    .nmi_flag(nmi_flag), .nmi_en(nmi_en),
    .sng_flag(sng_flag), .sng_en(sng_en),
    .tmr_flag(tmr_flag), .tmr_en(tmr_en),
    .pa_flag(pa_flag), .pa_en(pa_en),
    .pb_flag(pb_flag), .pb_en(pb_en),
    .rst_src(rst_src), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .irq_ack(irq_ack), .irq_req(irq_req), .pend_vec(pend_vec),
    .vec_addr(vec_addr), .sng_clr(sng_clr), .gie_clr(gie_clr),
    .nmi_en_clr(nmi_en_clr), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sng_lvl_ref(input int i);
    int t[5] = '{12, 10, 6, 3, 0};
    return t[i];
  endfunction

  // highest pending level from the requirement text, -1 if none
  function automatic int exp_lvl();
    int best = -1;
    if (|(nmi_flag & nmi_en)) best = 14;
    if (gie) begin
      for (int i = 0; i < 5; i++)
        if (sng_flag[i] && sng_en[i] && sng_lvl_ref(i) > best) best = sng_lvl_ref(i);
      if (|(tmr_flag & tmr_en) && best < 5) best = 5;
      if (|(pa_flag & pa_en) && best < 4) best = 4;
      if (|(pb_flag & pb_en) && best < 1) best = 1;
    end
    return best;
  endfunction

  task automatic chk_pend(input string req);
    int l = exp_lvl();
    #1;
    chk(req, {31'd0, irq_req}, {31'd0, (l >= 0)});
    if (l >= 0) chk(req, {16'd0, pend_vec}, 32'hFFE0 + 2 * l);
  endtask

  task automatic clear_all();
    gie = 0; nmi_flag = 0; nmi_en = 0; sng_flag = 0; sng_en = 0;
    tmr_flag = 0; tmr_en = 0; pa_flag = 0; pa_en = 0; pb_flag = 0; pb_en = 0;
  endtask

  function automatic bit bad_fetch(input int a);
    return (a <= 32'h01FF) || (a >= 32'h0300 && a <= 32'h0BFF) ||
           (a >= 32'h1100 && a <= 32'h7FFF);
  endfunction

  // acknowledge the current winner, then check the outputs after the edge
  task automatic do_ack(input string req, input logic [15:0] exp_vec,
                        input logic [4:0] exp_clr, input bit exp_g, input bit exp_n);
    @(negedge clk); irq_ack = 1;
    @(posedge clk); #1; irq_ack = 0;
    chk(req, {16'd0, vec_addr}, {16'd0, exp_vec});
    chk(req, {27'd0, sng_clr}, {27'd0, exp_clr});
    chk(req, {30'd0, gie_clr, nmi_en_clr}, {30'd0, exp_g, exp_n});
    @(posedge clk); #1;
    chk(req, {27'd0, sng_clr, gie_clr, nmi_en_clr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", {16'd0, vec_addr}, 32'hFFFE);
    chk("R12", {31'd0, sys_rst_req}, 32'd0);
    chk("R3", {31'd0, irq_req}, 32'd0);

    // R1 R3: each single source under every gie/enable combination
    for (int i = 0; i < 5; i++)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); clear_all();
        sng_flag[i] = 1; sng_en[i] = c[0]; gie = c[1];
        chk_pend("R3");
      end

    // R2: non-maskable tier, all flag/enable/gie patterns
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 8; e++)
        for (int g = 0; g < 2; g++) begin
          @(negedge clk); clear_all();
          nmi_flag = f[2:0]; nmi_en = e[2:0]; gie = g[0];
          sng_flag = 5'h1F; sng_en = 5'h1F;
          chk_pend("R2");
        end

    // R4: every grouped flag alone, enabled and disabled
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 2; c++) begin
        @(negedge clk); clear_all(); gie = 1;
        pa_flag[k] = 1; pa_en = c[0] ? (8'h1 << k) : ~(8'h1 << k);
        chk_pend("R4");
        @(negedge clk); clear_all(); gie = 1;
        pb_flag[k] = 1; pb_en = c[0] ? (8'h1 << k) : ~(8'h1 << k);
        chk_pend("R4");
        if (k < 3) begin
          @(negedge clk); clear_all(); gie = 1;
          tmr_flag[k] = 1; tmr_en = c[0] ? (3'h1 << k) : ~(3'h1 << k);
          chk_pend("R4");
        end
      end

    // R1 R5: priority across all single-flag patterns combined with groups
    for (int s = 0; s < 32; s++)
      for (int grp = 0; grp < 8; grp++) begin
        @(negedge clk); clear_all(); gie = 1;
        sng_flag = s[4:0]; sng_en = 5'h1F;
        tmr_flag = {2'b0, grp[0]}; tmr_en = 3'h7;
        pa_flag = {7'b0, grp[1]}; pa_en = 8'hFF;
        pb_flag = {7'b0, grp[2]}; pb_en = 8'hFF;
        chk_pend("R1");
      end

    // R6 R7 R8: acknowledge of a single-source maskable level (level 10)
    @(negedge clk); clear_all(); gie = 1; sng_flag = 5'b00010; sng_en = 5'h1F;
    do_ack("R7", 16'hFFF4, 5'b00010, 1'b1, 1'b0);
    @(negedge clk); sng_flag = 5'b00001;
    repeat (3) @(posedge clk);
    #1 chk("R6", {16'd0, vec_addr}, 32'hFFF4);
    // R8: grouped port A level, no flag clear
    @(negedge clk); clear_all(); gie = 1; pa_flag = 8'h80; pa_en = 8'h80;
    do_ack("R8", 16'hFFE8, 5'b0, 1'b1, 1'b0);
    // R8: non-maskable level
    @(negedge clk); clear_all(); nmi_flag = 3'b010; nmi_en = 3'b010;
    do_ack("R8", 16'hFFFC, 5'b0, 1'b0, 1'b1);
    // R7: lowest single-source level 0
    @(negedge clk); clear_all(); gie = 1; sng_flag = 5'b10000; sng_en = 5'b10000;
    do_ack("R7", 16'hFFE0, 5'b10000, 1'b1, 1'b0);
    // R6: acknowledge with nothing pending is ignored
    @(negedge clk); clear_all();
    do_ack("R6", 16'hFFE0, 5'b0, 1'b0, 1'b0);

    // R9 R10: every address fetched, result one cycle later
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk); fetch_valid = 1; fetch_addr = a[15:0];
      @(posedge clk); #1;
      chk(bad_fetch(a) ? "R9" : "R10", {31'd0, sys_rst_req}, {31'd0, bad_fetch(a)});
    end
    @(negedge clk); fetch_valid = 0;
    @(posedge clk); #1;
    chk("R12", {16'd0, vec_addr}, 32'hFFFE);

    // R11: data accesses to the same ranges
    for (int a = 0; a < 65536; a += 64) begin
      @(negedge clk); fetch_valid = 0; fetch_addr = a[15:0];
      @(posedge clk); #1;
      chk("R11", {31'd0, sys_rst_req}, 32'd0);
    end

    // R12: each reset cause; vector forced to reset word
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); clear_all(); gie = 1; sng_flag = 5'b00100; sng_en = 5'h1F;
      do_ack("R6", 16'hFFEC, 5'b00100, 1'b1, 1'b0);
      @(negedge clk); rst_src = 3'b1 << b;
      @(posedge clk); #1;
      chk("R12", {31'd0, sys_rst_req}, 32'd1);
      chk("R12", {16'd0, vec_addr}, 32'hFFFE);
      @(negedge clk); rst_src = 0;
      @(posedge clk); #1;
      chk("R12", {31'd0, sys_rst_req}, 32'd0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule